// File: doc/BRIEF.md
# Peripheral Bus Address Violation Monitor

This block watches a simple peripheral bus (setup phase, then access phase) and tests each access address against a parameterised set of valid address windows. The peripheral bus has no way to report an error, so an access that hits no window is still completed: the monitor drives the ready strobe itself and keeps the error strobe low. The upstream system-bus side therefore also sees a normal OK completion. Accesses inside a window are left for the addressed slave to complete.

When a stray access occurs and no earlier fault is being held, the monitor records the faulting address and the 4-bit ID of the master that issued it. It raises a one-cycle interrupt and locks the record. While the record is locked, later stray accesses are still completed but are not recorded and raise no interrupt. Software reads the record through a small registered read port. Reading the address register releases the lock, and the next stray access is recorded again.

Top module: `pbus_guard`

## Requirements
- R1: In the access phase (`psel_i` and `penable_i` both high), when the address lies in no window, `pready_o` is high in that same cycle. When the address lies inside a window, `pready_o` stays low. `pslverr_o` is low at all times.
- R2: An address is valid when `base <= addr <= limit` holds for at least one window. Both bounds are inclusive. The default windows are 0x0000–0x00FF, 0x1000–0x13FF and 0x8000–0x8FFF.
- R3: The first stray access seen while the record is unlocked gives `irq_o` high for exactly the one cycle after its access phase. The record then locks.
- R4: The captured address is returned when selector 0 is read.
- R5: The captured master ID is returned, zero-extended, when selector 1 is read.
- R6: While the record is locked, stray accesses raise no interrupt and leave both captured registers unchanged.
- R7: A read request returns `rd_valid_o` high, with its data, one cycle later. Selector 2 returns the lock flag in bit 0. Selector 3 returns zero.
- R8: A selector-0 read releases the lock on the clock edge that follows the edge that returned its data. A status read issued back-to-back with it still reports the lock as set, and the read after that reports it clear. Reads of selectors 1 and 2 never release the lock.
- R9: After reset, the lock is clear, both captured registers read zero and `irq_o` is low.
- R10: A setup phase on its own (`psel_i` high, `penable_i` low) is not an access. It drives no ready and is never recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access-phase strobe |
| paddr_i | input | ADDR_W | Access address |
| pmaster_i | input | MID_W | ID of the master that issued the access |
| pready_o | output | 1 | Completion driven for stray accesses |
| pslverr_o | output | 1 | Error strobe, held low |
| irq_o | output | 1 | Violation interrupt pulse |
| rd_req_i | input | 1 | Diagnostic read request |
| rd_sel_i | input | 2 | Selector: 0 address, 1 master ID, 2 status, 3 none |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | ADDR_W | Read data |

## Verification
The hardest situation to reach is the one-cycle gap between the return of the address read and the release of the lock. For the bench to see that gap, a status read must land on exactly the next edge. The bench therefore issues the address read and two status reads back-to-back. It expects the lock as set, then as clear, and then shows that a new stray access is captured again. The window decode is covered by sweeping 256 spread addresses across the whole range, plus the addresses on either side of each window bound. The expected validity is computed from the window list held in the bench.

// File: rtl/pbus_guard_pkg.sv
package pbus_guard_pkg;
    localparam int MID_W = 4;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_MID  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/pbus_guard_decode.sv
module pbus_guard_decode #(
    parameter int                        ADDR_W  = 16,
    parameter int                        NUM_WIN = 3,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE  = '0,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LIMIT = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [NUM_WIN-1:0] win_hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE  = WIN_BASE[w*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] LIMIT = WIN_LIMIT[w*ADDR_W +: ADDR_W];
        assign win_hit[w] = (addr_i >= BASE) && (addr_i <= LIMIT);
    end

    assign hit_o = |win_hit;
endmodule

// File: rtl/pbus_guard_capture.sv
module pbus_guard_capture #(
    parameter int ADDR_W = 16,
    parameter int MID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MID_W-1:0]  mid_i,
    input  logic              clr_i,
    output logic              lock_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [MID_W-1:0]  mid_o
);
    typedef struct packed {
        logic              lock;
        logic              irq;
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  mid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.irq = 1'b0;
        if (viol_i && !cap_q.lock) begin
            cap_d.lock = 1'b1;
            cap_d.irq  = 1'b1;
            cap_d.addr = addr_i;
            cap_d.mid  = mid_i;
        end else if (clr_i) begin
            cap_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign lock_o = cap_q.lock;
    assign irq_o  = cap_q.irq;
    assign addr_o = cap_q.addr;
    assign mid_o  = cap_q.mid;

    // R3: the interrupt lasts one cycle and only comes with a held record
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.irq |=> !cap_q.irq);
    p_irq_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.irq |-> cap_q.lock);
    // R6: a held record does not move until released
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.lock && !clr_i) |=> ($stable(cap_q.addr) && $stable(cap_q.mid) && cap_q.lock));
    // R8: a release request unlocks on the following edge
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && cap_q.lock) |=> !cap_q.lock);
endmodule

// File: rtl/pbus_guard_readport.sv
module pbus_guard_readport
    import pbus_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [1:0]        rd_sel_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic [MID_W-1:0]  cap_mid_i,
    input  logic              lock_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_data_o,
    output logic              clr_o
);
    typedef struct packed {
        logic              valid;
        logic              clr;
        logic [ADDR_W-1:0] data;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d       = '0;
        rp_d.valid = rd_req_i;
        if (rd_req_i) begin
            unique case (rd_sel_e'(rd_sel_i))
                SEL_ADDR: begin
                    rp_d.data = cap_addr_i;
                    rp_d.clr  = 1'b1;
                end
                SEL_MID:  rp_d.data = {{(ADDR_W-MID_W){1'b0}}, cap_mid_i};
                SEL_STAT: rp_d.data = {{(ADDR_W-1){1'b0}}, lock_i};
                default:  rp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign rd_valid_o = rp_q.valid;
    assign rd_data_o  = rp_q.data;
    assign clr_o      = rp_q.clr;

    // R7: every request is answered one cycle later
    p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o);
    // R8: only a returned address read requests the release
    p_clr_only_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> rd_valid_o);
endmodule

// File: rtl/pbus_guard.sv
module pbus_guard
    import pbus_guard_pkg::*;
#(
    parameter int                        ADDR_W  = 16,
    parameter int                        NUM_WIN = 3,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE  = {16'h8000, 16'h1000, 16'h0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LIMIT = {16'h8FFF, 16'h13FF, 16'h00FF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [MID_W-1:0]  pmaster_i,
    output logic              pready_o,
    output logic              pslverr_o,
    output logic              irq_o,
    input  logic              rd_req_i,
    input  logic [1:0]        rd_sel_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_data_o
);
    logic              hit;
    logic              viol;
    logic              lock;
    logic              clr;
    logic [ADDR_W-1:0] cap_addr;
    logic [MID_W-1:0]  cap_mid;

    pbus_guard_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_LIMIT(WIN_LIMIT)
    ) u_decode (
        .addr_i(paddr_i),
        .hit_o (hit)
    );

    assign viol      = psel_i && penable_i && !hit;
    assign pready_o  = viol;
    assign pslverr_o = 1'b0;

    pbus_guard_capture #(
        .ADDR_W(ADDR_W),
        .MID_W (MID_W)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .viol_i(viol),
        .addr_i(paddr_i),
        .mid_i (pmaster_i),
        .clr_i (clr),
        .lock_o(lock),
        .irq_o (irq_o),
        .addr_o(cap_addr),
        .mid_o (cap_mid)
    );

    pbus_guard_readport #(
        .ADDR_W(ADDR_W),
        .MID_W (MID_W)
    ) u_readport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req_i  (rd_req_i),
        .rd_sel_i  (rd_sel_i),
        .cap_addr_i(cap_addr),
        .cap_mid_i (cap_mid),
        .lock_i    (lock),
        .rd_valid_o(rd_valid_o),
        .rd_data_o (rd_data_o),
        .clr_o     (clr)
    );

    // R10: no ready without the access phase
    p_setup_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel_i && penable_i) |-> !pready_o);
    // R3: an interrupt always follows a stray access phase
    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pready_o));
endmodule

// File: tb/pbus_guard_bench.sv
`timescale 1ns/1ps
module pbus_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0;
    logic [15:0] paddr = '0;
    logic [3:0]  pmaster = '0;
    logic        pready, pslverr, irq;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic        rd_valid;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pbus_guard u_pbus_guard (
        .clk(clk), .rst_n(rst_n),
        .psel_i(psel), .penable_i(penable), .paddr_i(paddr), .pmaster_i(pmaster),
        .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq),
        .rd_req_i(rd_req), .rd_sel_i(rd_sel),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    function automatic bit in_window(input logic [15:0] a);
        return (a <= 16'h00FF) || (a >= 16'h1000 && a <= 16'h13FF) ||
               (a >= 16'h8000 && a <= 16'h8FFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // entered and left at a falling edge
    task automatic access(input logic [15:0] a, input logic [3:0] id, input bit expect_irq);
        psel = 1'b1; penable = 1'b0; paddr = a; pmaster = id;
        #1 check("R10 no ready in setup", pready, 0);
        @(negedge clk);
        penable = 1'b1;
        #1;
        check("R1/R2 ready on stray access", pready, !in_window(a));
        check("R1 error strobe low", pslverr, 0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        check("R3/R6 interrupt", irq, expect_irq);
    endtask

    task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string req);
        rd_req = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_req = 1'b0;
        check("R7 read valid", rd_valid, 1);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 irq after reset", irq, 0);
        rd(2'd0, 16'h0000, "R9 address reg after reset");
        rd(2'd1, 16'h0000, "R9 master reg after reset");
        rd(2'd2, 16'h0000, "R9 lock after reset");
        check("R10 no ready idle", pready, 0);

        // R10 setup phase alone is not an access
        psel = 1'b1; paddr = 16'h4000;
        @(negedge clk);
        check("R10 setup-only ready", pready, 0);
        psel = 1'b0;
        @(negedge clk);
        check("R10 setup-only irq", irq, 0);
        rd(2'd2, 16'h0000, "R10 setup-only not recorded");

        // R2 sweep plus window bounds; R3 R4 R5 R8 per stray access
        for (int i = 0; i < 280; i++) begin
            logic [15:0] a;
            logic [3:0]  id;
            if (i < 256) a = 16'(i << 8) | 16'(i);
            else begin
                case ((i - 256) % 4)
                    0: a = 16'h0100;
                    1: a = 16'h0FFF;
                    2: a = 16'h1400;
                    default: a = 16'h7FFF;
                endcase
                if (i >= 264) a = (i % 2 == 0) ? 16'h9000 : 16'hFFFF;
                if (i >= 270) a = (i % 2 == 0) ? 16'h1000 : 16'h13FF;
                if (i >= 274) a = (i % 2 == 0) ? 16'h8000 : 16'h8FFF;
                if (i >= 278) a = (i % 2 == 0) ? 16'h0000 : 16'h00FF;
            end
            id = 4'(i * 7);
            access(a, id, !in_window(a));
            if (!in_window(a)) begin
                rd(2'd1, {12'h000, id}, "R5 captured master id");
                rd(2'd0, a, "R4 captured address");
            end
        end

        // R6 lock holds; R8 release timing
        access(16'h2222, 4'hA, 1'b1);
        access(16'h3333, 4'h5, 1'b0);
        access(16'hF000, 4'h3, 1'b0);
        rd(2'd2, 16'h0001, "R7 lock flag set");
        rd(2'd1, 16'h000A, "R6 master id held");
        rd(2'd2, 16'h0001, "R8 id read does not release");
        rd(2'd3, 16'h0000, "R7 selector 3 zero");
        rd(2'd0, 16'h2222, "R6 address held");
        rd(2'd2, 16'h0001, "R8 lock still set on return edge");
        rd(2'd2, 16'h0000, "R8 lock released next edge");
        access(16'h3333, 4'h5, 1'b1);
        rd(2'd0, 16'h3333, "R8 capture after release");
        rd(2'd1, 16'h0005, "R5 new master id");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule